// File: doc/BRIEF.md
# Timer/Event Counter with Power-Down Wake-Up

This block is an 8-bit upward counter with a software-programmed reload value. It advances either on ticks from a prescaler, which divides the system clock by a power of two, or on rising edges of an external event pin. The event pin is synchronized to the system clock first.

When the counter steps past all-ones it reloads the stored value in the same cycle and sets an interrupt request flag. The interrupt output is gated by a global enable and a timer enable. While the device is powered down, an overflow also raises a wake-up output, whatever the enables are. The one exception is when the request flag was already set at the moment power-down began. Software sets the block up through a small write port with three register selects.

Top module: `evt_timer`

## Requirements
- R1: A write with select 0 stores the reload value; if the run bit is clear at that time the counter is also loaded with the written value on the next clock edge. Reset clears the counter, the flag and all outputs.
- R2: Control write (select 1) with bits [7:6] = 2'b10 selects timer mode; bits [2:0] = n divide the clock by 2^(n+1), so 0x91 (0x81 plus run) counts once every 4 clocks, the first step landing 4 edges after the run bit is written.
- R3: Control bit 4 is the run bit; while it is clear the counter holds its value.
- R4: A step taken at 0xFF reloads the stored reload value on the same edge and sets the request flag (interrupt-control bit 5); the flag is visible on req_o.
- R5: irq_o is high only when the request flag, the global enable (interrupt-control bit 0) and the timer enable (interrupt-control bit 2) are all set; 0x05 sets both enables.
- R6: A write with select 2 loads both enables and the flag from bits 0, 2 and 5; if an overflow occurs on the same edge, the flag ends up set.
- R7: Control bits [7:6] = 2'b01 select event mode: each rising edge on ext_evt adds one, applied on the third clock edge after the pin rises, also while pdown is high.
- R8: An overflow while pdown is high sets wake_o whatever the enables are; wake_o stays high until pdown is seen low, then clears on the next edge.
- R9: If the request flag is already set in the cycle pdown first goes high, no overflow during that power-down raises wake_o.
- R10: Mode codes 2'b00 and 2'b11 never advance the counter, even with the run bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 reload, 1 control, 2 interrupt control |
| wr_data | input | 8 | Write data |
| ext_evt | input | 1 | Asynchronous external event pin |
| pdown | input | 1 | Device is in power-down |
| count_o | output | 8 | Current counter value |
| req_o | output | 1 | Timer interrupt request flag |
| irq_o | output | 1 | Masked interrupt request |
| wake_o | output | 1 | Wake-up request, held during power-down |

## Verification
An overflow and a software write to the interrupt-control register can fall on the same clock edge, and so can an overflow and the entry into power-down. The first case is provoked with a divide-by-2 timer started from 0xFE, which places the overflow exactly four edges after the run bit. A write that clears the flag is timed to commit on that edge. The result is judged by the flag remaining set and the counter showing the reload value. Wake-up suppression is judged by entering power-down with the flag already high and forcing an event-mode overflow, and by repeating the run with the flag clear.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    typedef enum logic [1:0] {
        SEL_PRE  = 2'd0,
        SEL_CTL  = 2'd1,
        SEL_INT  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_EVT = 2'b01,
        MODE_TMR = 2'b10,
        MODE_RSV = 2'b11
    } mode_e;

    // control register field positions
    localparam int MODE_LSB = 6;
    localparam int RUN_BIT  = 4;

    // interrupt-control register field positions
    localparam int GIE_BIT  = 0;
    localparam int TIE_BIT  = 2;
    localparam int FLAG_BIT = 5;

endpackage

// File: rtl/evt_timer_presc.sv
module evt_timer_presc #(
    parameter int PSC_W = 8,
    localparam int SEL_W = $clog2(PSC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } psc_t;

    psc_t st_d, st_q;
    logic [PSC_W-1:0] mask;

    always_comb begin
        // low (sel+1) bits set: period of 2^(sel+1) clocks
        mask   = {PSC_W{1'b1}} >> (PSC_W - 1 - int'(sel));
        tick   = en && ((st_q.cnt & mask) == mask);
        st_d   = st_q;
        st_d.cnt = en ? st_q.cnt + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/evt_timer_edge.sv
module evt_timer_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    typedef struct packed {
        logic [STAGES:0] sh;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-1:0], din};
        // last synchronizer stage high, history stage low
        rise    = st_q.sh[STAGES-1] && !st_q.sh[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/evt_timer_cnt.sv
module evt_timer_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] count,
    output logic         ovf
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        ovf   = step && (st_q.cnt == {W{1'b1}});
        if (load)      st_d.cnt = load_val;
        else if (ovf)  st_d.cnt = reload_val;
        else if (step) st_d.cnt = st_q.cnt + 1'b1;
        count = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int W           = 8,
    parameter int PSC_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         ext_evt,
    input  logic         pdown,
    output logic [W-1:0] count_o,
    output logic         req_o,
    output logic         irq_o,
    output logic         wake_o
);
    localparam int SEL_W = $clog2(PSC_W);

    typedef struct packed {
        logic [W-1:0]     pre;
        logic [1:0]       mode;
        logic             run;
        logic [SEL_W-1:0] ps;
        logic             gie;
        logic             tie;
        logic             flag;
        logic             pd;
        logic             arm;
        logic             wake;
    } regs_t;

    regs_t st_d, st_q;

    logic         wr_pre, wr_ctl, wr_int;
    logic         run, tmr_en, evt_en;
    logic         tmr_tick, evt_rise, step, load, ovf, arm_now;
    logic [W-1:0] reload_val;

    assign run        = st_q.run;
    assign reload_val = st_q.pre;
    assign tmr_en     = run && (st_q.mode == MODE_TMR);
    assign evt_en     = run && (st_q.mode == MODE_EVT);

    evt_timer_presc #(.PSC_W(PSC_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tmr_en),
        .sel   (st_q.ps),
        .tick  (tmr_tick)
    );

    evt_timer_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_evt),
        .rise  (evt_rise)
    );

    evt_timer_cnt #(.W(W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .load       (load),
        .load_val   (wr_data),
        .reload_val (reload_val),
        .count      (count_o),
        .ovf        (ovf)
    );

    always_comb begin
        wr_pre  = wr_en && (wr_sel == SEL_PRE);
        wr_ctl  = wr_en && (wr_sel == SEL_CTL);
        wr_int  = wr_en && (wr_sel == SEL_INT);
        step    = (tmr_en && tmr_tick) || (evt_en && evt_rise);
        load    = wr_pre && !run;
        // arming is sampled in the first power-down cycle, then held
        arm_now = st_q.pd ? st_q.arm : !st_q.flag;

        st_d = st_q;
        if (wr_pre) st_d.pre = wr_data;
        if (wr_ctl) begin
            st_d.mode = wr_data[MODE_LSB+1:MODE_LSB];
            st_d.run  = wr_data[RUN_BIT];
            st_d.ps   = wr_data[SEL_W-1:0];
        end
        if (wr_int) begin
            st_d.gie  = wr_data[GIE_BIT];
            st_d.tie  = wr_data[TIE_BIT];
            st_d.flag = wr_data[FLAG_BIT];
        end
        if (ovf) st_d.flag = 1'b1;     // hardware set beats software write

        st_d.pd  = pdown;
        st_d.arm = arm_now;
        if (!pdown)               st_d.wake = 1'b0;
        else if (ovf && arm_now)  st_d.wake = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o  = st_q.flag;
    assign irq_o  = st_q.flag && st_q.gie && st_q.tie;
    assign wake_o = st_q.wake;
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
    import evt_timer_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [1:0]   wr_sel,
    input logic [W-1:0] count_o,
    input logic [W-1:0] reload_val,
    input logic         req_o,
    input logic         wake_o,
    input logic         pdown,
    input logic         ovf,
    input logic         run
);
    // R4: counter shows the reload value right after an overflow
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (count_o == $past(reload_val)));

    // R4/R6: an overflow always leaves the flag set, even against a write
    a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> req_o);

    // R3: a stopped counter only changes through a reload-register write
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(wr_en && wr_sel == SEL_PRE)) |=> $stable(count_o));

    // R8: leaving power-down drops the wake-up request
    a_r8_wake_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !pdown |=> !wake_o);

    // R8: a wake-up request only starts from an overflow
    a_r8_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> $past(ovf));
endmodule

bind evt_timer evt_timer_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .count_o    (count_o),
    .reload_val (reload_val),
    .req_o      (req_o),
    .wake_o     (wake_o),
    .pdown      (pdown),
    .ovf        (ovf),
    .run        (run)
);

// File: tb/evt_timer_bench.sv
module evt_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {reload value, prescale code, edges to wait}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h9B, 8'd1, 8'd40},
        {8'hFE, 8'd0, 8'd10},
        {8'hF0, 8'd2, 8'd200},
        {8'h00, 8'd0, 8'd30},
        {8'hF8, 8'd7, 8'd255},
        {8'hFF, 8'd0, 8'd2}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd3;
    logic [7:0] wr_data = 8'h00;
    logic       ext_evt = 1'b0;
    logic       pdown = 1'b0;
    logic [7:0] count_o;
    logic       req_o, irq_o, wake_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    logic [7:0] snap;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_timer u_evt_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ext_evt(ext_evt), .pdown(pdown),
        .count_o(count_o), .req_o(req_o), .irq_o(irq_o), .wake_o(wake_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic pulse();
        @(negedge clk);
        ext_evt = 1'b1;
        repeat (3) @(negedge clk);
        ext_evt = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // reference: count after a number of steps, plus whether any wrap occurred
    function automatic logic [8:0] model(input logic [7:0] p, input int steps);
        logic [7:0] c = p;
        logic       f = 1'b0;
        for (int i = 0; i < steps; i++) begin
            if (c == 8'hFF) begin c = p; f = 1'b1; end
            else c = c + 8'd1;
        end
        return {f, c};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset count", count_o, 0);
        chk("R4 reset flag", req_o, 0);
        chk("R5 reset irq", irq_o, 0);
        chk("R8 reset wake", wake_o, 0);

        // R2/R4 timer-mode table
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] p;
            int ps, k;
            logic [8:0] e;
            p  = VEC[i][23:16];
            ps = int'(VEC[i][15:8]);
            k  = int'(VEC[i][7:0]);
            wr(2'd1, 8'h00);
            wr(2'd2, 8'h00);
            wr(2'd0, p);
            wr(2'd1, 8'h90 | 8'(ps));
            repeat (k) @(posedge clk);
            @(negedge clk);
            e = model(p, k / (1 << (ps + 1)));
            chk("R2 timer count", count_o, e[7:0]);
            chk("R4 overflow flag", req_o, e[8]);
        end

        // R3: run bit stops counting; R1 load while stopped
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h10);
        chk("R1 load while stopped", count_o, 8'h10);
        wr(2'd1, 8'h91);
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk("R2 divide by 4", count_o, 8'h15);
        wr(2'd1, 8'h81);
        snap = count_o;
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk("R3 hold when stopped", count_o, snap);
        wr(2'd0, 8'h33);
        chk("R1 load while stopped", count_o, 8'h33);

        // R10: reserved mode codes never count
        wr(2'd1, 8'h10);
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk("R10 mode 00 idle", count_o, 8'h33);
        wr(2'd1, 8'hD0);
        pulse();
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk("R10 mode 11 idle", count_o, 8'h33);
        wr(2'd1, 8'h00);

        // R5/R6: interrupt gating and software flag access
        wr(2'd2, 8'h25);
        chk("R6 software set", req_o, 1);
        chk("R5 irq enabled", irq_o, 1);
        wr(2'd2, 8'h21);
        chk("R5 irq timer enable off", irq_o, 0);
        wr(2'd2, 8'h24);
        chk("R5 irq global enable off", irq_o, 0);
        wr(2'd2, 8'h05);
        chk("R6 software clear", req_o, 0);
        chk("R5 irq no flag", irq_o, 0);

        // R6: overflow and clearing write on the same edge
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'hFE);
        wr(2'd1, 8'h90);
        repeat (3) @(posedge clk);
        wr(2'd2, 8'h00);
        chk("R6 overflow beats clear", req_o, 1);
        chk("R4 reload on overflow", count_o, 8'hFE);

        // R7: event counting
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h40);
        wr(2'd1, 8'h50);
        for (int j = 0; j < 5; j++) pulse();
        repeat (4) @(negedge clk);
        chk("R7 event count", count_o, 8'h45);
        wr(2'd1, 8'h00);

        // R8: wake with interrupts masked, flag clear at entry
        wr(2'd2, 8'h00);
        wr(2'd0, 8'hFE);
        pdown = 1'b1;
        repeat (3) @(negedge clk);
        wr(2'd1, 8'h50);
        pulse();
        chk("R7 count in power-down", count_o, 8'hFF);
        chk("R8 no wake before overflow", wake_o, 0);
        pulse();
        chk("R8 wake while masked", wake_o, 1);
        chk("R5 irq masked", irq_o, 0);
        chk("R4 flag on event overflow", req_o, 1);
        chk("R4 event reload", count_o, 8'hFE);
        pdown = 1'b0;
        @(negedge clk);
        chk("R8 wake clears", wake_o, 0);

        // R9: flag already set at power-down entry
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h20);
        wr(2'd0, 8'hFF);
        pdown = 1'b1;
        repeat (3) @(negedge clk);
        wr(2'd1, 8'h50);
        pulse();
        chk("R9 overflow happened", count_o, 8'hFF);
        chk("R9 no wake", wake_o, 0);
        chk("R9 flag still set", req_o, 1);
        pdown = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule